// File: doc/BRIEF.md
# Serial Port FIFO Register Front End

This block sits between a processor bus and the serial shifter of a serial port. It holds a receive queue and a transmit queue, each 16 bytes deep by default. Every received byte is stored together with its own parity, framing and break flags. Software sees two 32-bit words: a data port and a line-control word.

A read of the data port returns the oldest received byte, that byte's error flags and both fill levels. The read has no side effect. Software drops the oldest received byte by writing the line-control word with its discard strobe set. A write to the data port queues its low byte for transmission. The shifter takes bytes from the transmit side with a single take strobe, and offers received bytes with a push strobe. The line-control word also holds the character format and the forced-break bit, which go straight to the shifter.

Each queue is controlled by a three-state fill machine. Its states are EMPTY, PARTIAL and FULL. These are its transitions:
- EMPTY to PARTIAL on an accepted push.
- PARTIAL to FULL on a push with no pop when one slot is left.
- PARTIAL to EMPTY on a pop with no push when one entry is left.
- FULL to PARTIAL on a pop.
- PARTIAL or FULL to EMPTY on a flush.

Top module: `uart_fifo_regs`

## Requirements
- R1: The line-control word is at bus address 0 and the data port is at address 1. A data-port read returns these fields, with every other bit zero:
  - bits 7:0: the receive head byte.
  - bits 12:8: the receive fill count.
  - bit 13: the head's parity flag.
  - bit 14: the head's framing flag.
  - bit 15: the head's break flag.
  - bits 20:16: the transmit fill count.
- R2: Reading the data port never removes an entry. Repeated reads with no other activity return the same value.
- R3: A line-control write with bit 16 set discards the receive head from the next cycle onward, and the next entry becomes the head. A discard on an empty receive queue is ignored. A push and a discard in the same cycle both take effect.
- R4: The receive queue holds DEPTH entries, and its count never exceeds DEPTH. A push into a full receive queue is dropped and leaves the contents and order unchanged. It also raises rx_overrun for exactly one cycle, the cycle after the push.
- R5: When the head entry's break flag is set, bits 14 and 13 of the data port read as zero, whatever was stored.
- R6: When the receive queue is empty, bits 7:0 and 15:13 of the data port read as zero.
- R7: A data-port write queues bus_wdata[7:0] for transmission. The bytes appear on tx_byte in write order while tx_avail is high, and each cycle with tx_take high and tx_avail high removes one. The transmit queue holds DEPTH bytes, and writes to a full queue are dropped.
- R8: A line-control write with bit 17 set empties the receive queue. Bit 18 set empties the transmit queue. Both take effect in the next cycle.
- R9: The line-control bits are stored and drive these outputs:
  - bit 24 drives cfg_eight_bit.
  - bit 26 drives cfg_two_stop.
  - bit 27 drives cfg_par_en.
  - bit 28 drives cfg_par_even.
  - bit 30 drives cfg_tx_break.

  A read of address 0 returns exactly those stored bits. Strobe bits 16 to 18 and all other bits read as zero.
- R10: A receive flush wins over a receive push in the same cycle. The queue ends empty and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable for a selected access |
| bus_addr | input | ADDR_W | Word address (0 line control, 1 data port) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rx_push | input | 1 | Shifter offers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error for the offered byte |
| rx_frm_err | input | 1 | Framing error for the offered byte |
| rx_brk | input | 1 | Break condition for the offered byte |
| rx_overrun | output | 1 | One-cycle pulse: a byte was dropped |
| tx_avail | output | 1 | Transmit queue holds a byte |
| tx_byte | output | 8 | Oldest byte of the transmit queue |
| tx_take | input | 1 | Shifter consumes tx_byte |
| cfg_eight_bit | output | 1 | Eight data bits (else seven) |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_par_en | output | 1 | Parity enabled |
| cfg_par_even | output | 1 | Even parity |
| cfg_tx_break | output | 1 | Force the transmit line to break |

## Verification
The bench aims at these corner cases:
- A 17th received byte must be dropped while the head and the order are kept. A design that wrapped its pointer would overwrite the oldest byte and report a count of zero.
- A discard on an empty queue and a flush in the same cycle as a push must leave the count at zero. A design that let the count underflow would show 31 here, and one that let the push win would show a stray entry.
- A break entry stored with parity and framing flags set must read with those two bits cleared. Repeated reads must return the same value, which catches any read-side pop.
- Transmit bytes are checked against a scoreboard across a fill past 16 and a flush, so a lost pointer reset or a dropped-write miscount shows up as a wrong byte.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int BYTE_W = 8;

    // Line-control bit positions
    localparam int LC_POP_BIT   = 16;
    localparam int LC_RXRST_BIT = 17;
    localparam int LC_TXRST_BIT = 18;
    localparam int LC_8BIT_BIT  = 24;
    localparam int LC_2STOP_BIT = 26;
    localparam int LC_PAREN_BIT = 27;
    localparam int LC_PAREV_BIT = 28;
    localparam int LC_BRK_BIT   = 30;

    // Data-port field positions
    localparam int DP_RXCNT_LSB = 8;
    localparam int DP_PAR_BIT   = 13;
    localparam int DP_FRM_BIT   = 14;
    localparam int DP_BRK_BIT   = 15;
    localparam int DP_TXCNT_LSB = 16;
    localparam int DP_CNT_W     = 5;

    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic tx_break;
        logic par_even;
        logic par_en;
        logic two_stop;
        logic eight_bit;
    } line_cfg_t;

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo
    import uart_fifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           push,
    input  logic [WIDTH-1:0]               push_data,
    input  logic                           pop,
    output logic [WIDTH-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    fill_state_e     state, state_nxt;
    logic [CW-1:0]   cnt_q, cnt_nxt;
    logic [AW-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [WIDTH-1:0] mem [DEPTH];
    logic            do_push, do_pop;

    assign do_push = push && (state != FS_FULL) && !flush;
    assign do_pop  = pop  && (state != FS_EMPTY) && !flush;

    assign wr_nxt = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
    assign rd_nxt = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;

    always_comb begin
        if (flush) cnt_nxt = '0;
        else       cnt_nxt = cnt_q + CW'(do_push) - CW'(do_pop);
    end

    // Fill-state transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            FS_EMPTY: begin
                if (do_push) state_nxt = FS_PARTIAL;
            end
            FS_PARTIAL: begin
                if (flush)
                    state_nxt = FS_EMPTY;
                else if (do_push && !do_pop && cnt_q == CW'(DEPTH-1))
                    state_nxt = FS_FULL;
                else if (do_pop && !do_push && cnt_q == CW'(1))
                    state_nxt = FS_EMPTY;
            end
            FS_FULL: begin
                if (flush)       state_nxt = FS_EMPTY;
                else if (do_pop) state_nxt = FS_PARTIAL;
            end
            default: state_nxt = FS_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FS_EMPTY;
            cnt_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            state <= state_nxt;
            cnt_q <= cnt_nxt;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push) wr_ptr <= wr_nxt;
                if (do_pop)  rd_ptr <= rd_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Outputs
    always_comb begin
        empty = (state == FS_EMPTY);
        full  = (state == FS_FULL);
        count = cnt_q;
        head  = mem[rd_ptr];
    end

endmodule

// File: rtl/uart_line_ctrl.sv
module uart_line_ctrl
    import uart_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output line_cfg_t   cfg,
    output logic [31:0] cfg_word,
    output logic        pop_stb,
    output logic        rx_flush_stb,
    output logic        tx_flush_stb
);

    line_cfg_t cfg_q;
    logic      unused_wbits;

    assign unused_wbits = ^{wdata[15:0], wdata[23:19], wdata[25], wdata[29], wdata[31]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.eight_bit <= wdata[LC_8BIT_BIT];
            cfg_q.two_stop  <= wdata[LC_2STOP_BIT];
            cfg_q.par_en    <= wdata[LC_PAREN_BIT];
            cfg_q.par_even  <= wdata[LC_PAREV_BIT];
            cfg_q.tx_break  <= wdata[LC_BRK_BIT];
        end
    end

    // Strobes act in the write cycle and are never stored
    always_comb begin
        pop_stb      = wr_en && wdata[LC_POP_BIT];
        rx_flush_stb = wr_en && wdata[LC_RXRST_BIT];
        tx_flush_stb = wr_en && wdata[LC_TXRST_BIT];
        cfg          = cfg_q;
        cfg_word     = '0;
        cfg_word[LC_8BIT_BIT]  = cfg_q.eight_bit;
        cfg_word[LC_2STOP_BIT] = cfg_q.two_stop;
        cfg_word[LC_PAREN_BIT] = cfg_q.par_en;
        cfg_word[LC_PAREV_BIT] = cfg_q.par_even;
        cfg_word[LC_BRK_BIT]   = cfg_q.tx_break;
    end

endmodule

// File: rtl/uart_reg_readback.sv
module uart_reg_readback
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFS = 0,
    parameter int DATA_OFS = 1
) (
    input  logic [ADDR_W-1:0]          addr,
    input  rx_entry_t                  rx_head,
    input  logic                       rx_empty,
    input  logic [$clog2(DEPTH+1)-1:0] rx_count,
    input  logic [$clog2(DEPTH+1)-1:0] tx_count,
    input  logic [31:0]                cfg_word,
    output logic [31:0]                rdata
);

    rx_entry_t shown;

    always_comb begin
        shown = rx_empty ? '0 : rx_head;
        if (shown.brk) begin
            shown.frm = 1'b0;
            shown.par = 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(DATA_OFS)) begin
            rdata[BYTE_W-1:0] = shown.data;
            rdata[DP_RXCNT_LSB +: DP_CNT_W] = DP_CNT_W'(rx_count);
            rdata[DP_PAR_BIT] = shown.par;
            rdata[DP_FRM_BIT] = shown.frm;
            rdata[DP_BRK_BIT] = shown.brk;
            rdata[DP_TXCNT_LSB +: DP_CNT_W] = DP_CNT_W'(tx_count);
        end else if (addr == ADDR_W'(CTRL_OFS)) begin
            rdata = cfg_word;
        end
    end

endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFS = 0,
    parameter int DATA_OFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    output logic              rx_overrun,
    output logic              tx_avail,
    output logic [7:0]        tx_byte,
    input  logic              tx_take,
    output logic              cfg_eight_bit,
    output logic              cfg_two_stop,
    output logic              cfg_par_en,
    output logic              cfg_par_even,
    output logic              cfg_tx_break
);

    localparam int CW      = $clog2(DEPTH+1);
    localparam int ENTRY_W = $bits(rx_entry_t);

    logic          ctrl_wr, data_wr;
    line_cfg_t     cfg;
    logic [31:0]   cfg_word;
    logic          pop_stb, rx_flush, tx_flush;
    rx_entry_t     rx_in, rx_head;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_empty, rx_full, tx_empty, tx_full;
    logic          overrun_q;
    logic          unused_txfull;

    assign ctrl_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
    assign data_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(DATA_OFS));
    assign unused_txfull = tx_full;

    assign rx_in = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, data: rx_byte};

    uart_line_ctrl u_lcr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (ctrl_wr),
        .wdata        (bus_wdata),
        .cfg          (cfg),
        .cfg_word     (cfg_word),
        .pop_stb      (pop_stb),
        .rx_flush_stb (rx_flush),
        .tx_flush_stb (tx_flush)
    );

    uart_byte_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_in),
        .pop       (pop_stb),
        .head      (rx_head),
        .count     (rx_count),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    uart_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (data_wr),
        .push_data (bus_wdata[BYTE_W-1:0]),
        .pop       (tx_take),
        .head      (tx_byte),
        .count     (tx_count),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    uart_reg_readback #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
    ) u_rb (
        .addr     (bus_addr),
        .rx_head  (rx_head),
        .rx_empty (rx_empty),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .cfg_word (cfg_word),
        .rdata    (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) overrun_q <= 1'b0;
        else        overrun_q <= rx_push && rx_full && !rx_flush;
    end

    always_comb begin
        rx_overrun    = overrun_q;
        tx_avail      = !tx_empty;
        cfg_eight_bit = cfg.eight_bit;
        cfg_two_stop  = cfg.two_stop;
        cfg_par_en    = cfg.par_en;
        cfg_par_even  = cfg.par_even;
        cfg_tx_break  = cfg.tx_break;
    end

endmodule

// File: rtl/uart_fifo_regs_chk.sv
module uart_fifo_regs_chk #(
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFS = 0,
    parameter int DATA_OFS = 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [31:0]                bus_rdata,
    input logic                       rx_push,
    input logic                       rx_overrun,
    input logic                       tx_avail,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic [$clog2(DEPTH+1)-1:0] tx_count
);

    localparam int CW = $clog2(DEPTH+1);

    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[31:19], bus_wdata[16:0]};

    // R5
    brk_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(DATA_OFS) && bus_rdata[15]) |-> (bus_rdata[14:13] == 2'b00));

    // R6
    empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(DATA_OFS) && rx_count == '0) |->
            (bus_rdata[7:0] == 8'h00 && bus_rdata[15:13] == 3'b000));

    // R4
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rx_push) && $past(rx_count) == CW'(DEPTH)));

    // R4
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    // R7
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));

    // R7
    tx_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_avail == (tx_count != '0));

    // R9
    strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(CTRL_OFS)) |-> (bus_rdata[18:16] == 3'b000));

    // R8
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(CTRL_OFS) && bus_wdata[17]) |=> (rx_count == '0));

    // R8
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(CTRL_OFS) && bus_wdata[18]) |=> (tx_count == '0));

endmodule

bind uart_fifo_regs uart_fifo_regs_chk #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_push    (rx_push),
    .rx_overrun (rx_overrun),
    .tx_avail   (tx_avail),
    .rx_count   (rx_count),
    .tx_count   (tx_count)
);

// File: tb/tb_uart_fifo_regs.sv
module tb_uart_fifo_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
    logic        rx_overrun, tx_avail, tx_take = 1'b0;
    logic [7:0]  tx_byte;
    logic        cfg_eight_bit, cfg_two_stop, cfg_par_en, cfg_par_even, cfg_tx_break;

    always #5 clk = ~clk;

    uart_fifo_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rx_overrun(rx_overrun),
        .tx_avail(tx_avail), .tx_byte(tx_byte), .tx_take(tx_take),
        .cfg_eight_bit(cfg_eight_bit), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_tx_break(cfg_tx_break)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [10:0] rxq[$];   // {brk, frm, par, byte}
    logic [7:0]  txq[$];
    logic [31:0] cfg_sh = '0;
    localparam logic [31:0] CFG_MASK = 32'h5D00_0000;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_data();
        logic [10:0] h;
        h = (rxq.size() > 0) ? rxq[0] : 11'd0;
        return {11'd0, 5'(txq.size()), h[10], h[9] & ~h[10], h[8] & ~h[10],
                5'(rxq.size()), h[7:0]};
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_data(string req);
        logic [31:0] v;
        rd(4'd1, v);
        check(req, v, exp_data());
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_we = 1'b0;
        if (a == 4'd0) begin
            cfg_sh = d & CFG_MASK;
            if (d[17]) rxq.delete();
            else if (d[16] && rxq.size() > 0) void'(rxq.pop_front());
            if (d[18]) txq.delete();
        end else if (a == 4'd1 && txq.size() < 16) begin
            txq.push_back(d[7:0]);
        end
    endtask

    task automatic pop_rx();
        wr(4'd0, cfg_sh | 32'h0001_0000);
    endtask

    task automatic rx_send(input logic [7:0] b, input logic p, input logic f, input logic k);
        bit was_full;
        was_full = (rxq.size() == 16);
        rx_push = 1'b1; rx_byte = b; rx_par_err = p; rx_frm_err = f; rx_brk = k;
        step();
        rx_push = 1'b0;
        if (!was_full) rxq.push_back({k, f, p, b});
        check(was_full ? "R4 overrun pulse" : "R4 no overrun", 32'(rx_overrun), 32'(was_full));
        if (was_full) begin
            step();
            check("R4 overrun one cycle", 32'(rx_overrun), 32'd0);
        end
    endtask

    // Transmit monitor: compares each consumed byte with the scoreboard
    always @(negedge clk) begin
        if (rst_n && tx_take) begin
            if (tx_avail) begin
                if (txq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R7 tx byte actual=%h expected=none", tx_byte);
                end else begin
                    check("R7 tx order", 32'(tx_byte), 32'(txq.pop_front()));
                end
            end else if (txq.size() != 0) begin
                checks++; fails++;
                $display("FAIL R7 tx_avail actual=0 expected=1");
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) step();
        // Reset state
        check_data("R1 reset data port");
        rd(4'd0, v); check("R9 reset ctrl", v, 32'd0);
        check("R7 reset tx_avail", 32'(tx_avail), 32'd0);
        check("R4 reset overrun", 32'(rx_overrun), 32'd0);
        rst_n = 1'b1;
        step();

        // R9: configuration bits
        wr(4'd0, 32'h5D00_0000);
        rd(4'd0, v); check("R9 readback all", v, 32'h5D00_0000);
        check("R9 cfg outputs", 32'({cfg_tx_break, cfg_par_even, cfg_par_en, cfg_two_stop, cfg_eight_bit}), 32'h1F);
        wr(4'd0, 32'h0507_0001);
        rd(4'd0, v); check("R9 strobes read zero", v, 32'h0500_0000);
        check("R9 cfg outputs 2", 32'({cfg_tx_break, cfg_par_even, cfg_par_en, cfg_two_stop, cfg_eight_bit}), 32'h03);

        // R1, R2: layout and non-destructive read
        rx_send(8'hA5, 0, 0, 0);
        rx_send(8'h3C, 1, 0, 0);
        rx_send(8'h7E, 0, 1, 0);
        wr(4'd1, 32'hFFFF_FF42);
        check_data("R1 layout");
        step();
        check_data("R2 repeat read");
        check_data("R2 repeat read again");

        // R3: discard head
        pop_rx(); check_data("R3 parity head");
        pop_rx(); check_data("R3 framing head");

        // R5: break masks parity and framing
        rx_send(8'h00, 1, 1, 1);
        pop_rx(); check_data("R5 break mask");
        rd(4'd1, v); check("R5 flags", {29'd0, v[15:13]}, 32'h4);

        // R6 and R3 empty pop
        pop_rx(); check_data("R6 empty head zero");
        pop_rx(); check_data("R3 empty pop ignored");

        // R3: simultaneous push and discard
        rx_send(8'h11, 0, 0, 0);
        rx_push = 1'b1; rx_byte = 8'h22; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = cfg_sh | 32'h0001_0000;
        step();
        rx_push = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        void'(rxq.pop_front()); rxq.push_back(11'h022);
        check_data("R3 push with pop");

        // R4: fill and overflow
        for (int i = 0; i < 15; i++) rx_send(8'(8'h30 + i), i[0], 0, 0);
        check_data("R4 full count");
        rx_send(8'hEE, 0, 0, 0);
        check_data("R4 dropped byte");
        for (int i = 0; i < 16; i++) begin
            check_data("R4 drain order");
            pop_rx();
        end
        check_data("R6 drained empty");

        // R7: transmit
        for (int i = 0; i < 4; i++) wr(4'd1, 32'hABCD_0050 + 32'(i));
        check_data("R7 tx count");
        tx_take = 1'b1;
        repeat (7) step();
        tx_take = 1'b0;
        check("R7 tx empty", 32'(tx_avail), 32'd0);
        for (int i = 0; i < 17; i++) wr(4'd1, 32'(8'h80 + i));
        check_data("R7 tx full drop");
        tx_take = 1'b1;
        repeat (3) step();
        tx_take = 1'b0;
        check_data("R7 partial drain");

        // R8: flushes
        wr(4'd0, cfg_sh | 32'h0004_0000);
        check_data("R8 tx flush");
        check("R8 tx_avail after flush", 32'(tx_avail), 32'd0);
        wr(4'd1, 32'h0000_00C1);
        wr(4'd1, 32'h0000_00C2);
        tx_take = 1'b1;
        repeat (3) step();
        tx_take = 1'b0;
        rx_send(8'h01, 0, 0, 0);
        rx_send(8'h02, 0, 0, 0);
        rx_send(8'h03, 0, 0, 0);
        wr(4'd0, cfg_sh | 32'h0002_0000);
        check_data("R8 rx flush");

        // R10: flush beats push
        rx_send(8'h04, 0, 0, 0);
        rx_push = 1'b1; rx_byte = 8'h05;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = cfg_sh | 32'h0002_0000;
        step();
        rx_push = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rxq.delete();
        check_data("R10 flush wins");
        check("R10 no overrun", 32'(rx_overrun), 32'd0);
        rx_send(8'h06, 0, 1, 0);
        check_data("R10 after flush");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule